// File: doc/BRIEF.md
# SPI Master with Switchable FIFOs

This block is the serial engine of an SPI master. The host pushes 16-bit words into a transmit queue. The engine takes one word at a time and shifts it out most significant bit first on `sout` with clock polarity 0 and clock phase 0. At the same time it assembles a word from `sin` and places that word in a receive queue, which the host drains through a show-ahead pop port. The serial clock comes from the system clock through a fixed divider: each half of the serial clock lasts `HALF_DIV` system clocks.

Each queue holds four entries by default. Either queue can be switched at run time down to a single holding entry, so that direction works as a plain double-buffered SPI. Write-one pulses flush each queue. A halt input stops new frames from starting, and a frame already on the wire still runs to its end. A module-disable input freezes the engine and holds the serial clock low, while pushes from the host are still accepted. For links with a slow return path, the capture of `sin` can be moved 0, 1 or 2 system clocks past the rising serial clock edge. The reserved delay code falls back to no delay and raises an error flag.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset both queues are empty with count 0, `sck` is low, `busy` is low, and `rx_ovf` and `smpl_err` are low when `smpl_pt` is 0.
- R2: The transmit queue holds up to DEPTH (4) words. `tx_full` rises when it holds 4, and a push while `tx_full` is high is dropped without changing the stored words or the count.
- R3: A frame is 16 bits, sent MSB first. `sck` is low when idle, `sout` changes only while `sck` is low, and each bit takes 2*HALF_DIV system clocks.
- R4: A one-cycle pulse on `tx_clr` empties the transmit queue (count 0, `tx_empty` high). While `tx_clr` is 0 the queue is untouched.
- R5: A one-cycle pulse on `rx_clr` empties the receive queue and clears `rx_ovf`.
- R6: With `tx_fifo_off` high the transmit queue holds a single word. `tx_full` is high at count 1, and further pushes are dropped.
- R7: With `rx_fifo_off` high the receive queue holds a single word. A second received frame that arrives before a pop is lost and sets `rx_ovf`.
- R8: A frame that completes while the receive queue is full is discarded, the stored words stay as they are, and `rx_ovf` stays high until `rx_clr`.
- R9: `smpl_pt` codes 0, 1 and 2 capture `sin` 0, 1 or 2 system clocks after the rising `sck` edge. The code is taken at the start of each frame.
- R10: `smpl_pt` code 3 acts as delay 0, and `smpl_err` is high exactly while the code is 3.
- R11: While `halt` is high no new frame starts. A frame in progress when `halt` rises completes, and the words left in the queue stay there.
- R12: While `mod_dis` is high `sck` stays low and no frame starts, but pushes to the transmit queue are still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_dis | input | 1 | Freeze the serial engine |
| tx_fifo_off | input | 1 | Reduce the transmit queue to one entry |
| rx_fifo_off | input | 1 | Reduce the receive queue to one entry |
| tx_clr | input | 1 | Write-one flush of the transmit queue |
| rx_clr | input | 1 | Write-one flush of the receive queue and overflow flag |
| halt | input | 1 | Hold off new frames |
| smpl_pt | input | 2 | Sample delay code |
| tx_push | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | DATA_W | Word to transmit |
| tx_full | output | 1 | Transmit queue at capacity |
| tx_empty | output | 1 | Transmit queue empty |
| tx_count | output | CW | Words in the transmit queue |
| rx_pop | input | 1 | Remove the head word of the receive queue |
| rx_data | output | DATA_W | Head word of the receive queue |
| rx_full | output | 1 | Receive queue at capacity |
| rx_empty | output | 1 | Receive queue empty |
| rx_count | output | CW | Words in the receive queue |
| rx_ovf | output | 1 | Sticky: a received frame was lost |
| smpl_err | output | 1 | Reserved sample code selected |
| busy | output | 1 | Frame in progress |
| sck | output | 1 | Serial clock |
| sout | output | 1 | Serial data out |
| sin | input | 1 | Serial data in |

## Verification
The bench uses the default build: 16-bit words, a depth of 4 and a half-period of 4 system clocks. A depth of 4 lets a short burst fill both queues and reach the overflow path. A half-period of 4 leaves room inside the high phase for all three delay settings, so a slave model that changes `sin` one system clock after the rising edge gives different words for delay 0 and for delays 1 and 2.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

   typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_e;

   // Reserved code 2'b11 maps to no delay.
   function automatic logic [1:0] smpl_delay(input logic [1:0] code);
      return (code == 2'b11) ? 2'd0 : code;
   endfunction

endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          off,
   input  logic          clr,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("spi_sync_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] cap;
   logic          do_push, do_pop;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign cap     = off ? CW'(1) : CW'(DEPTH);
   assign full    = (count >= cap);
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wr_ptr] <= wdata;
   end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_fifo_pkg::*;
#(
   parameter int W    = 16,
   parameter int HALF = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         halt,
   input  logic [1:0]   dly,
   input  logic         tx_empty,
   input  logic [W-1:0] tx_data,
   output logic         tx_pop,
   input  logic         sin,
   output logic         sck,
   output logic         sout,
   output logic         rx_push,
   output logic [W-1:0] rx_word,
   output logic         busy
);
   localparam int PW = $clog2(2 * HALF);
   localparam int BW = $clog2(W);

   generate
      if (HALF < 4) begin : g_bad_half
         $error("spi_shift_engine: HALF must be at least 4");
      end
      if (W < 2) begin : g_bad_w
         $error("spi_shift_engine: W must be at least 2");
      end
   endgenerate

   eng_state_e    state;
   logic [PW-1:0] ph;
   logic [BW-1:0] bitc;
   logic [W-1:0]  tx_sh, rx_sh;
   logic [1:0]    dly_q;
   logic          start;

   assign start  = (state == ENG_IDLE) && en && !halt && !tx_empty;
   assign tx_pop = start;
   assign busy   = (state == ENG_RUN);
   assign sck    = en && (state == ENG_RUN) && (ph >= PW'(HALF));
   assign sout   = tx_sh[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ENG_IDLE;
         ph      <= '0;
         bitc    <= '0;
         tx_sh   <= '0;
         rx_sh   <= '0;
         dly_q   <= '0;
         rx_push <= 1'b0;
         rx_word <= '0;
      end else begin
         rx_push <= 1'b0;
         if (en) begin
            case (state)
               ENG_IDLE: begin
                  if (start) begin
                     state <= ENG_RUN;
                     tx_sh <= tx_data;
                     ph    <= '0;
                     bitc  <= '0;
                     dly_q <= dly;
                  end
               end
               default: begin
                  if (ph == PW'(HALF) + PW'(dly_q))
                     rx_sh <= {rx_sh[W-2:0], sin};
                  if (ph == PW'(2 * HALF - 1)) begin
                     ph <= '0;
                     if (bitc == BW'(W - 1)) begin
                        state   <= ENG_IDLE;
                        rx_push <= 1'b1;
                        rx_word <= rx_sh;
                     end else begin
                        tx_sh <= {tx_sh[W-2:0], 1'b0};
                        bitc  <= bitc + 1'b1;
                     end
                  end else begin
                     ph <= ph + 1'b1;
                  end
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
   import spi_fifo_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int DEPTH    = 4,
   parameter int HALF_DIV = 4,
   localparam int CW      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_dis,
   input  logic              tx_fifo_off,
   input  logic              rx_fifo_off,
   input  logic              tx_clr,
   input  logic              rx_clr,
   input  logic              halt,
   input  logic [1:0]        smpl_pt,
   input  logic              tx_push,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_full,
   output logic              tx_empty,
   output logic [CW-1:0]     tx_count,
   input  logic              rx_pop,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              rx_empty,
   output logic [CW-1:0]     rx_count,
   output logic              rx_ovf,
   output logic              smpl_err,
   output logic              busy,
   output logic              sck,
   output logic              sout,
   input  logic              sin
);
   logic [DATA_W-1:0] tx_head, rx_word;
   logic              tx_pop, rx_push;

   spi_sync_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .off(tx_fifo_off), .clr(tx_clr),
      .push(tx_push), .wdata(tx_data), .pop(tx_pop), .rdata(tx_head),
      .count(tx_count), .full(tx_full), .empty(tx_empty)
   );

   spi_sync_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .off(rx_fifo_off), .clr(rx_clr),
      .push(rx_push), .wdata(rx_word), .pop(rx_pop), .rdata(rx_data),
      .count(rx_count), .full(rx_full), .empty(rx_empty)
   );

   spi_shift_engine #(.W(DATA_W), .HALF(HALF_DIV)) u_eng (
      .clk(clk), .rst_n(rst_n), .en(!mod_dis), .halt(halt),
      .dly(smpl_delay(smpl_pt)), .tx_empty(tx_empty), .tx_data(tx_head),
      .tx_pop(tx_pop), .sin(sin), .sck(sck), .sout(sout),
      .rx_push(rx_push), .rx_word(rx_word), .busy(busy)
   );

   assign smpl_err = (smpl_pt == 2'b11);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         rx_ovf <= 1'b0;
      else if (rx_clr)                    rx_ovf <= 1'b0;
      else if (rx_push && rx_full)        rx_ovf <= 1'b1;
   end

endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
   parameter int DEPTH = 4,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mod_dis,
   input logic          halt,
   input logic          tx_clr,
   input logic          rx_clr,
   input logic          tx_push,
   input logic          tx_full,
   input logic          tx_empty,
   input logic [CW-1:0] tx_count,
   input logic          rx_empty,
   input logic          rx_ovf,
   input logic          busy,
   input logic          sck,
   input logic          sout
);
   // R2: a push into a full queue never raises the count
   a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_full && tx_push && !tx_clr) |=> (tx_count <= $past(tx_count)));

   // R3: serial clock idle low between frames
   a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);

   // R3: data out holds steady while the serial clock is high
   a_r3_sout_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(sout));

   // R4: flush leaves the transmit queue empty
   a_r4_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
      tx_clr |=> (tx_empty && tx_count == '0));

   // R5: flush empties the receive queue and drops the overflow flag
   a_r5_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
      rx_clr |=> (rx_empty && !rx_ovf));

   // R11: no frame starts while halted
   a_r11_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !busy) |=> !busy);

   // R12: disabled engine starts nothing
   a_r12_dis_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_dis && !busy) |=> !busy);

endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/spi_fifo_master_tb.sv
`timescale 1ns/100ps
module spi_fifo_master_tb_top;
   localparam int W = 16;
   localparam int DEPTH = 4;
   localparam int CW = $clog2(DEPTH + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic mod_dis = 0, tx_fifo_off = 0, rx_fifo_off = 0, tx_clr = 0, rx_clr = 0;
   logic halt = 1, tx_push = 0, rx_pop = 0, sin = 0;
   logic [1:0] smpl_pt = 0;
   logic [W-1:0] tx_data = 0, rx_data;
   logic tx_full, tx_empty, rx_full, rx_empty, rx_ovf, smpl_err, busy, sck, sout;
   logic [CW-1:0] tx_count, rx_count;

   always #2.5 clk = ~clk;

   spi_fifo_master dut_i (.*);

   int checks = 0, errors = 0;
   bit done = 0;
   bit skew = 0;
   int nr = 0, mcnt = 0;
   logic [W-1:0] sw_a [8];
   logic [W-1:0] sw_b [8];
   logic [W-1:0] mrx = 0;
   logic [W-1:0] got_q[$];
   logic [W-1:0] exp_q[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic bit_of(input logic [W-1:0] arr [8], input int n);
      if (n / W >= 8) return 1'b0;
      return arr[n / W][W - 1 - (n % W)];
   endfunction

   // slave model: new bit after each falling edge
   always @(negedge sck) begin
      nr++;
      sin = bit_of(sw_a, nr);
   end
   // master data capture on rising edge
   always @(posedge sck) begin
      mrx = {mrx[W-2:0], sout};
      mcnt++;
      if (mcnt == W) begin got_q.push_back(mrx); mcnt = 0; end
   end
   // skewed slave: switch to the alternate bit one system clock after the rise
   always @(posedge sck) begin
      if (skew) begin
         @(posedge clk); #1;
         sin = bit_of(sw_b, nr);
      end
   end

   // per-clock comparison against the reference rules
   always @(negedge clk) begin
      if (rst_n) begin
         chk(smpl_err == (smpl_pt == 2'b11), "R10", "smpl_err", smpl_err, smpl_pt == 2'b11);
         if (mod_dis) chk(sck == 1'b0, "R12", "sck while disabled", sck, 0);
         if (!busy)   chk(sck == 1'b0, "R3", "sck idle", sck, 0);
      end
   end

   task automatic push(input logic [W-1:0] w);
      @(negedge clk); tx_push = 1; tx_data = w;
      @(negedge clk); tx_push = 0;
   endtask

   task automatic pulse_txclr();
      @(negedge clk); tx_clr = 1; @(negedge clk); tx_clr = 0;
   endtask

   task automatic pulse_rxclr();
      @(negedge clk); rx_clr = 1; @(negedge clk); rx_clr = 0;
   endtask

   task automatic burst();
      nr = 0; mcnt = 0;
      sin = bit_of(sw_a, 0);
      @(negedge clk); halt = 0;
      @(negedge clk);
      while (!(tx_empty && !busy)) @(negedge clk);
      halt = 1;
      repeat (4) @(negedge clk);
   endtask

   task automatic pop_chk(input logic [W-1:0] exp, input string req);
      @(negedge clk);
      chk(rx_data == exp, req, "rx_data", rx_data, exp);
      rx_pop = 1;
      @(negedge clk); rx_pop = 0;
   endtask

   task automatic chk_tx_words(input string req);
      chk(got_q.size() == exp_q.size(), req, "frames sent", got_q.size(), exp_q.size());
      while (exp_q.size() > 0 && got_q.size() > 0) begin
         logic [W-1:0] e, g;
         e = exp_q.pop_front(); g = got_q.pop_front();
         chk(g == e, req, "sout word", g, e);
      end
      exp_q.delete(); got_q.delete();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) begin
         sw_a[i] = 16'h1357 + 16'(i * 16'h1111);
         sw_b[i] = sw_a[i];
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(tx_empty && rx_empty, "R1", "queues empty", {tx_empty, rx_empty}, 3);
      chk(tx_count == 0 && rx_count == 0, "R1", "counts", tx_count, 0);
      chk(!sck && !busy && !rx_ovf && !smpl_err, "R1", "idle flags",
          {sck, busy, rx_ovf, smpl_err}, 0);

      // R2 fill and drop
      for (int i = 0; i < 5; i++) push(16'hA000 + 16'(i));
      chk(tx_count == 4 && tx_full, "R2", "tx count at full", tx_count, 4);
      // R4 flush, zero has no effect
      @(negedge clk);
      chk(tx_count == 4, "R4", "tx_clr low keeps count", tx_count, 4);
      pulse_txclr();
      chk(tx_count == 0 && tx_empty, "R4", "tx after flush", tx_count, 0);

      // R3 frames MSB first, three words
      for (int i = 0; i < 3; i++) begin push(16'hC0DE ^ 16'(i * 16'h0F0F)); exp_q.push_back(16'hC0DE ^ 16'(i * 16'h0F0F)); end
      chk(tx_count == 3, "R2", "tx count three", tx_count, 3);
      burst();
      chk_tx_words("R3");
      chk(rx_count == 3, "R9", "rx count after burst", rx_count, 3);
      for (int i = 0; i < 3; i++) pop_chk(sw_a[i], "R9");
      chk(rx_empty, "R9", "rx drained", rx_empty, 1);

      // R2 drop keeps stored words
      for (int i = 0; i < 5; i++) push(16'h5A00 + 16'(i));
      for (int i = 0; i < 4; i++) exp_q.push_back(16'h5A00 + 16'(i));
      burst();
      chk_tx_words("R2");
      chk(rx_count == 4 && rx_full, "R8", "rx full", rx_count, 4);
      chk(!rx_ovf, "R8", "no ovf yet", rx_ovf, 0);
      // R8 overflow: fifth frame lost
      push(16'h7777); exp_q.push_back(16'h7777);
      burst();
      chk_tx_words("R8");
      chk(rx_ovf && rx_count == 4, "R8", "ovf set count kept", {rx_ovf, rx_count}, {1'b1, 3'd4});
      pop_chk(sw_a[0], "R8");
      // R5 flush rx
      pulse_rxclr();
      chk(rx_empty && rx_count == 0 && !rx_ovf, "R5", "rx flushed", {rx_ovf, rx_count}, 0);

      // R9 delayed sampling with skewed slave
      sw_a[0] = 16'hA5C3; sw_b[0] = 16'h3C5A; skew = 1;
      for (int c = 0; c < 4; c++) begin
         logic [W-1:0] e;
         @(negedge clk); smpl_pt = 2'(c);
         push(16'h0101 * 16'(c + 1));
         burst();
         e = (c == 1 || c == 2) ? sw_b[0] : sw_a[0];
         pop_chk(e, (c == 3) ? "R10" : "R9");
      end
      got_q.delete();
      skew = 0; sw_b[0] = sw_a[0];
      @(negedge clk); smpl_pt = 0;

      // R6 tx queue off
      @(negedge clk); tx_fifo_off = 1;
      push(16'hBEEF); push(16'hDEAD);
      chk(tx_count == 1 && tx_full, "R6", "tx single entry", tx_count, 1);
      exp_q.push_back(16'hBEEF);
      burst();
      chk_tx_words("R6");
      @(negedge clk); tx_fifo_off = 0;
      pulse_rxclr();

      // R7 rx queue off
      @(negedge clk); rx_fifo_off = 1;
      push(16'h1111); push(16'h2222);
      burst();
      got_q.delete();
      chk(rx_count == 1 && rx_full && rx_ovf, "R7", "rx single with ovf",
          {rx_ovf, rx_count}, {1'b1, 3'd1});
      pop_chk(sw_a[0], "R7");
      @(negedge clk); rx_fifo_off = 0;
      pulse_rxclr();

      // R11 halt mid-frame
      push(16'h4242); push(16'h4343);
      nr = 0; mcnt = 0; sin = bit_of(sw_a, 0);
      @(negedge clk); halt = 0;
      @(negedge clk);
      chk(busy, "R11", "frame started", busy, 1);
      repeat (20) @(negedge clk);
      halt = 1;
      while (busy) @(negedge clk);
      repeat (200) @(negedge clk);
      chk(!busy && tx_count == 1, "R11", "halted with one left", tx_count, 1);
      chk(got_q.size() == 1, "R11", "one frame completed", got_q.size(), 1);
      if (got_q.size() > 0) chk(got_q[0] == 16'h4242, "R11", "completed word", got_q[0], 16'h4242);
      got_q.delete();
      pulse_txclr();
      pulse_rxclr();

      // R12 module disable
      @(negedge clk); mod_dis = 1; halt = 0;
      push(16'h9999);
      repeat (100) @(negedge clk);
      chk(!busy && tx_count == 1, "R12", "no start, push kept", {busy, tx_count}, 1);
      nr = 0; mcnt = 0; sin = bit_of(sw_a, 0);
      @(negedge clk); mod_dis = 0;
      @(negedge clk);
      while (busy) @(negedge clk);
      halt = 1;
      chk(got_q.size() == 1 && got_q[0] == 16'h9999, "R12", "frame after enable",
          (got_q.size() > 0) ? int'(got_q[0]) : -1, 16'h9999);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule